// File: doc/BRIEF.md
# Stack Pointer Offset Tracker

This decode-stage unit takes one classified instruction per cycle and keeps the stack pointer changes of that instruction stream in a private signed offset. The offset is measured against the last value the architectural stack pointer was synchronized to. Push, pop, call and return update the offset and do not issue a pointer-update micro-op. The unit hands each of these stack memory operations its address offset in the same cycle. Additions to and subtractions from the stack pointer by an immediate are absorbed completely and produce no output.

When software reads the stack pointer directly, a synchronization micro-op must bring the architectural register up to date first. The unit emits that micro-op, carrying the accumulated offset, and holds the input for one cycle. The same happens when an update would overflow the offset register. An explicit write to the stack pointer makes the pending offset meaningless, so the offset is dropped and no sync is issued. A flush input returns the tracker to a zero offset.

Top module: `sp_offset_tracker`

## Requirements
- R1: After reset the offset is zero. In a cycle with `flush` high, `out_valid` is 0, `in_ready` is 1 and the presented instruction is dropped. The offset is zero from the following cycle on.
- R2: Push (class 1) and call (class 3) are accepted in the same cycle. Each lowers the offset by 8 and passes out with `out_is_sync`=0 and `out_off` equal to the new, lowered offset.
- R3: Pop (class 2) and return (class 4) raise the offset by 8 and pass out with `out_off` equal to the offset as it stood before the increment.
- R4: Add to the stack pointer (class 5) adds the signed `in_imm` to the offset. Subtract (class 6) takes `in_imm` away from the offset. Neither produces an output (`out_valid`=0).
- R5: A direct stack pointer read (class 7) with a nonzero offset first yields a cycle with `out_valid`=1, `out_is_sync`=1, `out_off` equal to the offset and `in_ready`=0. The offset is then zero, and the read passes out in the next cycle with `out_off`=0. With a zero offset, the read passes out at once with no sync.
- R6: A direct stack pointer write (class 8) passes out with `out_off`=0 and no sync, and it resets the offset to zero.
- R7: If a class 1 to 6 update would take the offset outside the signed `OFF_W`-bit range, a sync cycle carrying the current offset comes first, with `in_ready`=0. The update is then applied from a zero offset.
- R8: Any other class (0, or 9 to 15) passes out with `out_off`=0 and leaves the offset unchanged. With `in_valid` low, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Clears the offset and drops the presented instruction |
| in_valid | input | 1 | An instruction is presented |
| in_class | input | 4 | Instruction class code |
| in_imm | input | IMM_W | Signed immediate for classes 5 and 6 |
| in_ready | output | 1 | Instruction accepted this cycle |
| out_valid | output | 1 | A micro-op is emitted this cycle |
| out_is_sync | output | 1 | The emitted micro-op is a synchronization |
| out_class | output | 4 | Class of the passed instruction |
| out_off | output | OFF_W | Address offset, or the accumulated offset on a sync |

## Verification
The bench drives more than 256 consecutive pushes. A design that checks the range late wraps the offset to a large positive value. One that checks it early emits a sync too soon. Reads are issued with both zero and nonzero offsets: a design that syncs unconditionally never releases the input, and one that never syncs leaves the offset uncleared. Flushes and stack pointer writes are each followed by a read, which shows at the ports whether the offset was really discarded. Pop and return checks catch an address taken from the updated offset instead of the prior one.

// File: rtl/sp_trk_pkg.sv
// Package: class codes shared by the tracker and its parts.
// Assumes a 4-bit class field. Codes not listed here behave as "other".
package sp_trk_pkg;
    typedef enum logic [3:0] {
        SPC_OTHER = 4'd0,
        SPC_PUSH  = 4'd1,
        SPC_POP   = 4'd2,
        SPC_CALL  = 4'd3,
        SPC_RET   = 4'd4,
        SPC_ADD   = 4'd5,
        SPC_SUB   = 4'd6,
        SPC_READ  = 4'd7,
        SPC_WRITE = 4'd8
    } sp_class_e;
endpackage

// File: rtl/sp_delta_decode.sv
// Module: turns a class code and an immediate into a signed offset delta plus
// the flags that say how the instruction uses the stack.
// Assumes IMM_W < OFF_W, so a single immediate from zero offset cannot overflow.
module sp_delta_decode
    import sp_trk_pkg::*;
#(
    parameter int OFF_W      = 12,
    parameter int IMM_W      = 10,
    parameter int SLOT_BYTES = 8
) (
    input  logic [3:0]           cls,
    input  logic [IMM_W-1:0]     imm,
    output logic signed [OFF_W:0] delta,
    output logic                 is_mem,
    output logic                 addr_post,
    output logic                 emits,
    output logic                 is_read,
    output logic                 is_write
);
    localparam int D_W = OFF_W + 1;
    localparam logic signed [D_W-1:0] STEP = D_W'(SLOT_BYTES);

    logic signed [D_W-1:0] imm_ext;
    assign imm_ext = D_W'($signed(imm));

    // Per-class delta and usage flags.
    always_comb begin
        delta     = '0;
        is_mem    = 1'b0;
        addr_post = 1'b0;
        emits     = 1'b1;
        is_read   = 1'b0;
        is_write  = 1'b0;
        case (cls)
            SPC_PUSH, SPC_CALL: begin
                delta = -STEP; is_mem = 1'b1; addr_post = 1'b1;
            end
            SPC_POP, SPC_RET: begin
                delta = STEP; is_mem = 1'b1;
            end
            SPC_ADD:   begin delta = imm_ext;  emits = 1'b0; end
            SPC_SUB:   begin delta = -imm_ext; emits = 1'b0; end
            SPC_READ:  is_read  = 1'b1;
            SPC_WRITE: is_write = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/sp_offset_reg.sv
// Module: holds the running stack pointer offset.
// Assumes flush takes priority over any update in the same cycle.
module sp_offset_reg #(
    parameter int OFF_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    upd_en,
    input  logic signed [OFF_W-1:0] upd_val,
    output logic signed [OFF_W-1:0] off_q
);
    // Offset register with reset, flush and update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) off_q <= '0;
        else if (upd_en)     off_q <= upd_val;
    end
endmodule

// File: rtl/sp_sync_ctrl.sv
// Module: decides for each presented instruction whether a sync micro-op
// must come first, forms the output micro-op and the next offset.
// Assumes the source holds its instruction while in_ready is low.
module sp_sync_ctrl #(
    parameter int OFF_W = 12
) (
    input  logic                    in_valid,
    input  logic                    flush,
    input  logic signed [OFF_W-1:0] off_q,
    input  logic signed [OFF_W:0]   delta,
    input  logic                    is_mem,
    input  logic                    addr_post,
    input  logic                    emits,
    input  logic                    is_read,
    input  logic                    is_write,
    output logic                    in_ready,
    output logic                    out_valid,
    output logic                    out_is_sync,
    output logic signed [OFF_W-1:0] out_off,
    output logic                    upd_en,
    output logic signed [OFF_W-1:0] upd_val
);
    localparam int D_W = OFF_W + 1;

    logic signed [D_W-1:0]   sum;
    logic                    ovf;
    logic                    need_sync;
    logic signed [OFF_W-1:0] new_off;

    // Widened sum and range check of the candidate offset.
    always_comb begin
        sum     = D_W'(off_q) + delta;
        ovf     = sum[D_W-1] != sum[D_W-2];
        new_off = sum[OFF_W-1:0];
    end

    assign need_sync = in_valid && !flush && ((is_read && off_q != '0) || ovf);

    // Output micro-op, back-pressure and offset update selection.
    always_comb begin
        in_ready    = 1'b1;
        out_valid   = 1'b0;
        out_is_sync = 1'b0;
        out_off     = '0;
        upd_en      = 1'b0;
        upd_val     = '0;
        if (need_sync) begin
            in_ready    = 1'b0;
            out_valid   = 1'b1;
            out_is_sync = 1'b1;
            out_off     = off_q;
            upd_en      = 1'b1;
        end else if (in_valid && !flush) begin
            upd_en    = 1'b1;
            upd_val   = is_write ? '0 : new_off;
            out_valid = emits;
            if (is_mem) out_off = addr_post ? new_off : off_q;
        end
    end
endmodule

// File: rtl/sp_offset_tracker.sv
// Module: top of the stack pointer offset tracker. It absorbs stack pointer
// arithmetic into a private offset and emits a sync micro-op on a direct read
// or before an overflow.
// Assumes one instruction per cycle with a valid/ready handshake on the input.
module sp_offset_tracker
    import sp_trk_pkg::*;
#(
    parameter int OFF_W      = 12,
    parameter int IMM_W      = 10,
    parameter int SLOT_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    in_valid,
    input  logic [3:0]              in_class,
    input  logic [IMM_W-1:0]        in_imm,
    output logic                    in_ready,
    output logic                    out_valid,
    output logic                    out_is_sync,
    output logic [3:0]              out_class,
    output logic signed [OFF_W-1:0] out_off
);
    logic signed [OFF_W:0]   delta;
    logic                    is_mem, addr_post, emits, is_read, is_write;
    logic                    upd_en;
    logic signed [OFF_W-1:0] upd_val;
    logic signed [OFF_W-1:0] off_q;

    assign out_class = in_class;

    sp_delta_decode #(.OFF_W(OFF_W), .IMM_W(IMM_W), .SLOT_BYTES(SLOT_BYTES)) u_dec (
        .cls(in_class), .imm(in_imm), .delta(delta), .is_mem(is_mem),
        .addr_post(addr_post), .emits(emits), .is_read(is_read), .is_write(is_write)
    );

    sp_sync_ctrl #(.OFF_W(OFF_W)) u_ctrl (
        .in_valid(in_valid), .flush(flush), .off_q(off_q), .delta(delta),
        .is_mem(is_mem), .addr_post(addr_post), .emits(emits), .is_read(is_read),
        .is_write(is_write), .in_ready(in_ready), .out_valid(out_valid),
        .out_is_sync(out_is_sync), .out_off(out_off), .upd_en(upd_en), .upd_val(upd_val)
    );

    sp_offset_reg #(.OFF_W(OFF_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .flush(flush), .upd_en(upd_en),
        .upd_val(upd_val), .off_q(off_q)
    );

    // R1: a flush leaves the offset at zero in the next cycle.
    a_r1_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> off_q == '0);

    // R2: an accepted push lowers the offset by one slot.
    a_r2_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !flush && in_class == SPC_PUSH) |=>
        (off_q == $past(off_q) - OFF_W'(SLOT_BYTES)));

    // R5: a sync cycle back-pressures the input and leaves a zero offset.
    a_r5_sync_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_sync) |-> !in_ready);
    a_r5_sync_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_sync && !flush) |=> off_q == '0);

    // R7: a sync never carries a zero offset.
    a_r7_sync_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_sync) |-> off_q != '0);

    // R1: nothing leaves the block in a flush cycle.
    a_r1_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !out_valid);
endmodule

// File: tb/sp_offset_tracker_bench.sv
module sp_offset_tracker_bench;
    localparam int OFF_W = 12;
    localparam int IMM_W = 10;
    localparam int SLOT  = 8;
    localparam int OMAX  = (1 << (OFF_W - 1)) - 1;
    localparam int OMIN  = -(1 << (OFF_W - 1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic in_valid = 1'b0;
    logic [3:0] in_class = '0;
    logic [IMM_W-1:0] in_imm = '0;
    logic in_ready, out_valid, out_is_sync;
    logic [3:0] out_class;
    logic signed [OFF_W-1:0] out_off;

    int checks = 0;
    int bad = 0;
    int model_off = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sp_offset_tracker #(.OFF_W(OFF_W), .IMM_W(IMM_W), .SLOT_BYTES(SLOT)) u_sp_offset_tracker (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_class(in_class), .in_imm(in_imm), .in_ready(in_ready),
        .out_valid(out_valid), .out_is_sync(out_is_sync),
        .out_class(out_class), .out_off(out_off)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int delta_of(input int cls, input int imm);
        case (cls)
            1, 3: return -SLOT;
            2, 4: return SLOT;
            5: return imm;
            6: return -imm;
            default: return 0;
        endcase
    endfunction

    // Presents one instruction until it is accepted, checking every cycle.
    task automatic issue(input int cls, input int imm, input string req);
        bit done = 1'b0;
        while (!done) begin
            int sum;
            bit need;
            @(negedge clk);
            flush = 1'b0; in_valid = 1'b1; in_class = cls[3:0]; in_imm = imm[IMM_W-1:0];
            #1;
            sum  = model_off + delta_of(cls, imm);
            need = (cls == 7 && model_off != 0) || sum > OMAX || sum < OMIN;
            if (need) begin
                chk(req, "sync valid", int'(out_valid), 1);
                chk(req, "sync flag", int'(out_is_sync), 1);
                chk(req, "sync ready", int'(in_ready), 0);
                chk(req, "sync offset", int'(out_off), model_off);
                model_off = 0;
            end else begin
                chk(req, "ready", int'(in_ready), 1);
                chk(req, "valid", int'(out_valid), (cls == 5 || cls == 6) ? 0 : 1);
                if (out_valid) begin
                    chk(req, "not sync", int'(out_is_sync), 0);
                    chk(req, "class", int'(out_class), cls);
                    if (cls == 1 || cls == 3)      chk(req, "addr", int'(out_off), sum);
                    else if (cls == 2 || cls == 4) chk(req, "addr", int'(out_off), model_off);
                    else                           chk(req, "off zero", int'(out_off), 0);
                end
                model_off = (cls == 8) ? 0 : sum;
                done = 1'b1;
            end
        end
    endtask

    task automatic idle();
        @(negedge clk);
        flush = 1'b0; in_valid = 1'b0;
        #1;
        chk("R8", "idle valid", int'(out_valid), 0);
    endtask

    task automatic do_flush(input bit with_instr);
        @(negedge clk);
        flush = 1'b1; in_valid = with_instr; in_class = 4'd1;
        #1;
        chk("R1", "flush valid", int'(out_valid), 0);
        chk("R1", "flush ready", int'(in_ready), 1);
        model_off = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, a read right after reset needs no sync
        issue(7, 0, "R1");
        // R2 / R3: push, call, pop, return
        issue(1, 0, "R2"); issue(3, 0, "R2");
        issue(2, 0, "R3"); issue(4, 0, "R3");
        issue(1, 0, "R2");
        // R4: folded immediates, then observed through a read sync
        issue(5, 100, "R4"); issue(6, -40, "R4");
        issue(7, 0, "R5");
        issue(7, 0, "R5");
        // R8: other class and idle
        issue(1, 0, "R2"); issue(0, 0, "R8"); issue(12, 0, "R8"); idle();
        issue(7, 0, "R8");
        // R6: write discards the offset, then a read needs no sync
        issue(1, 0, "R2"); issue(8, 0, "R6"); issue(7, 0, "R6");
        // R1: flush drops an instruction and clears the offset
        issue(6, 300, "R4"); do_flush(1'b1); issue(7, 0, "R1");
        // R7: push down to the floor and one beyond
        for (int i = 0; i < 257; i++) issue(1, 0, "R7");
        chk("R7", "offset after wrap push", model_off, -SLOT);
        issue(5, 511, "R7"); issue(5, 511, "R7"); issue(5, 511, "R7");
        issue(5, 511, "R7"); issue(5, 511, "R7");
        do_flush(1'b0);
        // Random mix
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom_range(0, 99);
            int imm = int'($urandom_range(0, 1023)) - 512;
            if (r < 3)       do_flush(r[0]);
            else if (r < 6)  idle();
            else if (r < 22) issue(1, 0, "R2");
            else if (r < 34) issue(2, 0, "R3");
            else if (r < 42) issue(3, 0, "R2");
            else if (r < 50) issue(4, 0, "R3");
            else if (r < 62) issue(5, imm, "R4");
            else if (r < 74) issue(6, imm, "R4");
            else if (r < 82) issue(7, 0, "R5");
            else if (r < 86) issue(8, 0, "R6");
            else             issue(int'($urandom_range(9, 15)) * (r & 1), 0, "R8");
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule